// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller for a multicycle load/store processor core. It steps through a fixed set of ten states. The state number advances on every clock. In each state the block drives the selects and enables that a separate datapath needs. That datapath holds the register file, the memory port, the ALU and the IR, A, B, MDR and ALUOut registers. The block covers five instruction classes: word load, word store, register-register ALU operation, branch-if-equal and absolute jump.

Every instruction starts with a fetch state and a decode state. The decode state reads both source registers. It also computes the branch target ahead of time, before the opcode is known to be a branch. The opcode then selects a class-specific path, and every path ends back at fetch. The datapath supplies the opcode field from IR and the ALU zero flag. Both must hold steady for the whole instruction. The state number is brought out so that the sequence can be watched.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A rising clock edge with `rst_n` low puts the block in state 0. While `rst_n` is low, every control output is 0.
- R2: State 0 (fetch) always leads to state 1. In state 0 the outputs are: mem_rd=1, mem_addr_sel=0 (PC), ir_load=1, alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_op=0 (add), pc_load=1, pc_src=0 (live ALU result).
- R3: State 1 (decode) drives alu_a_sel=0, alu_b_sel=3 (sign-extended offset shifted left 2) and alu_op=0, and asserts no enable. The next state is 2 for opcode 0x23 (load) or 0x2B (store), 6 for 0x00 (R-type), 8 for 0x04 (branch) and 9 for 0x02 (jump).
- R4: Any other opcode in state 1 sends the block back to state 0, with no register or memory write along the way.
- R5: State 2 drives alu_a_sel=1 (A), alu_b_sel=2 (sign-extended offset) and alu_op=0. It goes to state 3 for a load and to state 5 for a store.
- R6: State 3 drives mem_rd=1 with mem_addr_sel=1 (ALUOut) and goes to state 4. State 4 drives rf_wr=1, rf_dst_sel=0 (rt, bits 20-16) and rf_wsrc_sel=1 (MDR), then goes to state 0.
- R7: State 5 drives mem_wr=1 with mem_addr_sel=1 and goes to state 0.
- R8: State 6 drives alu_a_sel=1, alu_b_sel=0 (B) and alu_op=2 (function field), then goes to state 7. State 7 drives rf_wr=1, rf_dst_sel=1 (rd, bits 15-11) and rf_wsrc_sel=0 (ALUOut), then goes to state 0.
- R9: State 8 drives alu_a_sel=1, alu_b_sel=0, alu_op=1 (subtract) and pc_src=1 (ALUOut), with pc_load equal to alu_zero. It goes to state 0.
- R10: State 9 drives pc_load=1 with pc_src=2 (jump target) and goes to state 0.
- R11: mem_rd and mem_wr are never both 1, and at most one of rf_wr and mem_wr is 1. All outputs that a requirement above does not name are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| ir_load | output | 1 | Load the instruction register |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Write register: 0 rt, 1 rd |
| rf_wsrc_sel | output | 1 | Write data: 0 ALUOut, 1 MDR |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 four, 2 offset, 3 offset shifted |
| alu_op | output | 2 | 0 add, 1 subtract, 2 function field |
| pc_load | output | 1 | PC write enable |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target |
| state_o | output | 4 | Present state number |

## Verification
The state register is the only storage. A new state number is therefore visible one clock edge after the opcode and reset values that chose it. Every control output depends only on the present state, except pc_load in state 8, which follows alu_zero in the same cycle. The bench keeps a queue of the states that each issued instruction class should pass through. It pops one entry per clock edge and compares the state and all controls at the falling edge, which lets combinational outputs settle. Reset is asserted in the middle of an R-type instruction. The bench expects the controls to go quiet in that same cycle and the state to return to 0 one edge later.

// File: rtl/mcc_pkg.sv
// Package: shared state encoding, opcode codes and the control bundle
// for the multicycle controller. Assumes 6-bit opcodes.
package mcc_pkg;
    localparam int OP_W = 6;
    localparam int ST_W = 4;

    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LDMEM   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_STMEM   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_RWB     = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9
    } state_t;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_ld;
        logic       rf_wr;
        logic       rf_dst;
        logic       rf_wsrc;
        logic       alu_a;
        logic [1:0] alu_b;
        logic [1:0] alu_op;
        logic       pc_wr;
        logic       pc_wr_cond;
        logic [1:0] pc_src;
    } ctl_t;
endpackage

// File: rtl/mcc_next_state.sv
// Next-state rules: fixed successors, opcode dispatch out of decode and
// out of address calculation. Assumes the opcode is stable per instruction.
module mcc_next_state
    import mcc_pkg::*;
#(
    parameter logic [OP_W-1:0] P_LOAD  = OPC_LOAD,
    parameter logic [OP_W-1:0] P_STORE = OPC_STORE,
    parameter logic [OP_W-1:0] P_RTYPE = OPC_RTYPE,
    parameter logic [OP_W-1:0] P_BEQ   = OPC_BEQ,
    parameter logic [OP_W-1:0] P_JUMP  = OPC_JUMP
) (
    input  state_t          cur,
    input  logic [OP_W-1:0] opcode,
    output state_t          nxt
);
    // Pick the successor of the present state.
    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == P_LOAD || opcode == P_STORE) nxt = ST_ADDR;
                else if (opcode == P_RTYPE)                nxt = ST_EXEC;
                else if (opcode == P_BEQ)                  nxt = ST_BRANCH;
                else if (opcode == P_JUMP)                 nxt = ST_JUMP;
                else                                       nxt = ST_FETCH;
            end
            ST_ADDR: begin
                if (opcode == P_LOAD)       nxt = ST_LDMEM;
                else if (opcode == P_STORE) nxt = ST_STMEM;
                else                        nxt = ST_FETCH;
            end
            ST_LDMEM:  nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_RWB;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
// Output decode: maps a state to its control bundle and forms the PC
// write enable from the unconditional and zero-qualified requests.
// Unused selects are driven to 0.
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_t cur,
    input  logic   alu_zero,
    output ctl_t   ctl,
    output logic   pc_load
);
    // Per-state control values.
    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_ld  = 1'b1;
                ctl.alu_b  = 2'd1;
                ctl.pc_wr  = 1'b1;
            end
            ST_DECODE: ctl.alu_b = 2'd3;
            ST_ADDR: begin
                ctl.alu_a = 1'b1;
                ctl.alu_b = 2'd2;
            end
            ST_LDMEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_wr   = 1'b1;
                ctl.rf_wsrc = 1'b1;
            end
            ST_STMEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a  = 1'b1;
                ctl.alu_op = 2'd2;
            end
            ST_RWB: begin
                ctl.rf_wr  = 1'b1;
                ctl.rf_dst = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a      = 1'b1;
                ctl.alu_op     = 2'd1;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 2'd1;
            end
            ST_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = 2'd2;
            end
            default: ctl = '0;
        endcase
    end

    // PC write when unconditional or when a branch sees zero.
    always_comb pc_load = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
endmodule

// File: rtl/mc_ctrl_fsm.sv
// Top: state register plus next-state and output decode. All control
// outputs are held at 0 while rst_n is low. Assumes opcode and alu_zero
// come from datapath registers stable for the instruction.
module mc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            mem_addr_sel,
    output logic            ir_load,
    output logic            rf_wr,
    output logic            rf_dst_sel,
    output logic            rf_wsrc_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op,
    output logic            pc_load,
    output logic [1:0]      pc_src,
    output logic [ST_W-1:0] state_o
);
    state_t cur_q;
    state_t nxt;
    ctl_t   ctl;
    logic   pc_load_raw;

    mcc_next_state u_next (
        .cur    (cur_q),
        .opcode (opcode),
        .nxt    (nxt)
    );

    mcc_ctrl_decode u_dec (
        .cur      (cur_q),
        .alu_zero (alu_zero),
        .ctl      (ctl),
        .pc_load  (pc_load_raw)
    );

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= ST_FETCH;
        else        cur_q <= nxt;
    end

    // Drive outputs, silenced while reset is held.
    always_comb begin
        mem_rd       = rst_n & ctl.mem_rd;
        mem_wr       = rst_n & ctl.mem_wr;
        mem_addr_sel = rst_n & ctl.addr_sel;
        ir_load      = rst_n & ctl.ir_ld;
        rf_wr        = rst_n & ctl.rf_wr;
        rf_dst_sel   = rst_n & ctl.rf_dst;
        rf_wsrc_sel  = rst_n & ctl.rf_wsrc;
        alu_a_sel    = rst_n & ctl.alu_a;
        alu_b_sel    = rst_n ? ctl.alu_b  : 2'd0;
        alu_op       = rst_n ? ctl.alu_op : 2'd0;
        pc_load      = rst_n & pc_load_raw;
        pc_src       = rst_n ? ctl.pc_src : 2'd0;
        state_o      = cur_q;
    end
endmodule

// File: rtl/mcc_ctrl_chk.sv
// Checker: temporal properties of the controller, observed at its ports.
module mcc_ctrl_chk
    import mcc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] opcode,
    input logic            alu_zero,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic            mem_addr_sel,
    input logic            ir_load,
    input logic            rf_wr,
    input logic            pc_load,
    input logic [ST_W-1:0] state_o
);
    // R1: reset edge lands in fetch.
    p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> state_o == 4'd0);

    // R1: enables quiet during reset.
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!mem_rd && !mem_wr && !rf_wr && !pc_load && !ir_load);
        end
    end

    // R2: fetch always proceeds to decode.
    p_fetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd0 |=> state_o == 4'd1);

    // R3: R-type dispatch.
    p_rtype_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode == OPC_RTYPE) |=> state_o == 4'd6);

    // R4: unknown opcode returns to fetch.
    p_bad_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1 && opcode != OPC_LOAD && opcode != OPC_STORE &&
         opcode != OPC_RTYPE && opcode != OPC_BEQ && opcode != OPC_JUMP)
        |=> state_o == 4'd0);

    // R6: load read is followed by write-back.
    p_load_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd3 |=> (state_o == 4'd4 && rf_wr));

    // R7: memory write always addresses ALUOut.
    p_store_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr_sel);

    // R9: branch PC write follows zero.
    p_branch_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd8 |-> pc_load == alu_zero);

    // R10: jump returns to fetch.
    p_jump_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 4'd9 |=> state_o == 4'd0);

    // R11: read/write and write/write exclusivity.
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && $onehot0({rf_wr, mem_wr}));
endmodule

bind mc_ctrl_fsm mcc_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (opcode),
    .alu_zero     (alu_zero),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_addr_sel (mem_addr_sel),
    .ir_load      (ir_load),
    .rf_wr        (rf_wr),
    .pc_load      (pc_load),
    .state_o      (state_o)
);

// File: tb/mc_ctrl_fsm_tb.sv
// Bench: per-instruction queue of expected states, controls compared each cycle.
module mc_ctrl_fsm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_INSTR    = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic       mem_rd, mem_wr, mem_addr_sel, ir_load, rf_wr, rf_dst_sel, rf_wsrc_sel;
    logic       alu_a_sel, pc_load;
    logic [1:0] alu_b_sel, alu_op, pc_src;
    logic [3:0] state_o;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  exp_state = 0;
    int  path[$];
    logic [5:0] op_list [N_INSTR];
    logic       z_list  [N_INSTR];

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_sel(mem_addr_sel),
        .ir_load(ir_load), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel),
        .rf_wsrc_sel(rf_wsrc_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_load(pc_load), .pc_src(pc_src), .state_o(state_o)
    );

    // Expected control word {mem_rd,mem_wr,addr,ir,rf_wr,dst,wsrc,a,b[2],op[2],pcld,pcsrc[2]}.
    function automatic logic [14:0] expect_ctl(input int s, input logic z);
        logic rd = 0, wr = 0, ad = 0, ir = 0, rw = 0, ds = 0, ws = 0, a = 0, pl = 0;
        logic [1:0] b = 0, op = 0, ps = 0;
        case (s)
            0: begin rd = 1; ir = 1; b = 1; pl = 1; end
            1: b = 3;
            2: begin a = 1; b = 2; end
            3: begin rd = 1; ad = 1; end
            4: begin rw = 1; ws = 1; end
            5: begin wr = 1; ad = 1; end
            6: begin a = 1; op = 2; end
            7: begin rw = 1; ds = 1; end
            8: begin a = 1; op = 1; pl = z; ps = 1; end
            9: begin pl = 1; ps = 2; end
            default: ;
        endcase
        return {rd, wr, ad, ir, rw, ds, ws, a, b, op, pl, ps};
    endfunction

    function automatic string req_tag(input int s, input logic r, input logic [5:0] op);
        if (!r) return "R1";
        case (s)
            0: return "R2";
            1: return (op inside {6'h23, 6'h2B, 6'h00, 6'h04, 6'h02}) ? "R3" : "R4";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Load the expected state path for the issued opcode.
    task automatic issue(input logic [5:0] op, input logic z);
        opcode   = op;
        alu_zero = z;
        path.delete();
        case (op)
            6'h23: path = '{1, 2, 3, 4, 0};
            6'h2B: path = '{1, 2, 5, 0};
            6'h00: path = '{1, 6, 7, 0};
            6'h04: path = '{1, 8, 0};
            6'h02: path = '{1, 9, 0};
            default: path = '{1, 0};
        endcase
    endtask

    task automatic compare();
        logic [14:0] got, exp;
        got = {mem_rd, mem_wr, mem_addr_sel, ir_load, rf_wr, rf_dst_sel, rf_wsrc_sel,
               alu_a_sel, alu_b_sel, alu_op, pc_load, pc_src};
        exp = rst_n ? expect_ctl(exp_state, alu_zero) : 15'd0;
        n_vec++;
        if (got !== exp || state_o !== 4'(exp_state)) begin
            n_bad++;
            $display("FAIL %s state got=%0d exp=%0d ctl got=%h exp=%h",
                     req_tag(exp_state, rst_n, opcode), state_o, exp_state, got, exp);
        end
        n_vec++;
        if ((mem_rd & mem_wr) || (rf_wr & mem_wr)) begin
            n_bad++;
            $display("FAIL R11 exclusivity got rd=%b wr=%b rfw=%b exp no overlap",
                     mem_rd, mem_wr, rf_wr);
        end
    endtask

    initial begin
        int  idx = 0;
        int  rst_cnt = 3;
        bit  did_mid_rst = 0;
        op_list = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h04, 6'h02, 6'h3F,
                    6'h00, 6'h11, 6'h23, 6'h04, 6'h2B};
        z_list  = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                    1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            // State produced by the last rising edge.
            if (!rst_n) begin
                exp_state = 0;
                path.delete();
            end else if (path.size() > 0) begin
                exp_state = path.pop_front();
            end else begin
                exp_state = 1;
            end
            // Reset schedule: start-up, then once inside an R-type write-back.
            if (rst_cnt > 0) begin
                rst_cnt--;
                if (rst_cnt == 0) rst_n = 1'b1;
            end else if (exp_state == 7 && !did_mid_rst && idx > 3) begin
                rst_n = 1'b0;
                rst_cnt = 2;
                did_mid_rst = 1;
            end
            if (rst_n && exp_state == 0) begin
                if (idx == N_INSTR) break;
                issue(op_list[idx], z_list[idx]);
                idx++;
            end
            #1;
            compare();
            if (cyc == 399) begin
                n_bad++;
                $display("FAIL R2 run did not drain got idx=%0d exp=%0d", idx, N_INSTR);
            end
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL R2 watchdog expired got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule